// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the execute-stage arithmetic and logic unit of a 32-bit integer core. In one combinational pass it takes two operands, a 4-bit operation code, the current condition flags, the carry produced by the operand shifter and a set-flags request. It returns the result, a strobe that says whether the destination register should be written, and the next value of the flag nibble.

The operations fall into three groups. Logical operations are AND, exclusive OR, OR, bit clear, move and move-inverted, plus the two test forms. Additions are plain add, add with carry and compare-negative. Subtractions are plain, reversed, with carry, reversed with carry, and compare. Every group has its own carry and overflow rule.

The operand shifter sits in front of this block and stays outside it. Its carry-out arrives on `shc_i`. The caller owns the register file and the flag storage. It feeds the stored flags back on `flags_i` and stores `flags_o`.

Top module: `dp_alu`

## Requirements
- R1: Logical opcodes give these results: 0 a&b, 1 a^b, 8 a&b, 9 a^b, C a|b, D b, E a&~b, F ~b.
- R2: Arithmetic opcodes give these results, all modulo 2^32: 2 a−b, 3 b−a, 4 a+b, 5 a+b+C, 6 a−b−(1−C), 7 b−a−(1−C), A a−b, B a+b. C is the carry bit of `flags_i`.
- R3: `wr_en_o` is 0 for opcodes 8, 9, A and B. It is 1 for every other opcode.
- R4: The flag nibble is ordered N=bit 3, Z=bit 2, C=bit 1, V=bit 0. When `set_flags_i` is 1, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R5: For SUB, RSB and CMP with flags set, C is 1 when the subtrahend is no greater than the minuend as unsigned values. This means C=1 when no borrow occurs. For RSB the subtrahend is a.
- R6: For ADD, ADC and CMN with flags set, C is the carry out of bit 31. For ADC this is the OR of the carry of a+b and the carry of adding the carry-in to that 32-bit sum.
- R7: For SBC with flags set, C is 1 when (b − C_in + 1), computed without wrap, is no greater than a. RSC applies the same rule with a and b swapped.
- R8: With flags set, V for additions is bit 31 of (x^r)&(y^r). For subtractions x−y, V is bit 31 of (x^r)&(~y^r). Here x and y are the minuend and subtrahend after any swap.
- R9: For logical opcodes with flags set, C equals `shc_i` and V keeps its value from `flags_i`.
- R10: When `set_flags_i` is 0, `flags_o` equals `flags_i` for every opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand |
| b_i | input | W | Second operand, after the shifter |
| op_i | input | 4 | Operation code |
| flags_i | input | 4 | Current NZCV; the C bit is the carry-in |
| shc_i | input | 1 | Shifter carry-out |
| set_flags_i | input | 1 | Request flag update |
| result_o | output | W | Operation result |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next NZCV |

## Verification
The bench builds the block at the default W=32. At that width the bit-31 sign and carry boundaries can be hit directly with values such as 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF.

Every opcode is driven with both carry-in values across these edge pairs and across random pairs. This covers the two partial carries of ADC, the extended-subtrahend case of SBC with b=0xFFFFFFFF, and equal operands in the no-borrow compare.

A share of the items clear set-flags, so the hold rule is checked against the same operand patterns.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic arith;     // adder path drives result and C/V
    logic invert_y;  // subtract: add ~y
    logic swap;      // reverse operands
    logic use_cin;   // carry-in from stored C
    logic write_rd;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.write_rd = 1'b1;
    unique case (alu_op_e'(op_i))
      OP_SUB: begin ctrl_o.arith = 1'b1; ctrl_o.invert_y = 1'b1; end
      OP_RSB: begin ctrl_o.arith = 1'b1; ctrl_o.invert_y = 1'b1; ctrl_o.swap = 1'b1; end
      OP_ADD: ctrl_o.arith = 1'b1;
      OP_ADC: begin ctrl_o.arith = 1'b1; ctrl_o.use_cin = 1'b1; end
      OP_SBC: begin ctrl_o.arith = 1'b1; ctrl_o.invert_y = 1'b1; ctrl_o.use_cin = 1'b1; end
      OP_RSC: begin
        ctrl_o.arith = 1'b1; ctrl_o.invert_y = 1'b1;
        ctrl_o.use_cin = 1'b1; ctrl_o.swap = 1'b1;
      end
      OP_TST, OP_TEQ: ctrl_o.write_rd = 1'b0;
      OP_CMP: begin ctrl_o.arith = 1'b1; ctrl_o.invert_y = 1'b1; ctrl_o.write_rd = 1'b0; end
      OP_CMN: begin ctrl_o.arith = 1'b1; ctrl_o.write_rd = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         invert_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  localparam int EW = W + 1;
  logic [W-1:0]  y_eff;
  logic [EW-1:0] wide;

  // x + ~y + 1 carries exactly when y <= x; x + ~y + cin covers the borrow form
  assign y_eff = invert_i ? ~y_i : y_i;
  assign wide  = {1'b0, x_i} + {1'b0, y_eff} + {{(EW-1){1'b0}}, cin_i};
  assign sum_o = wide[W-1:0];
  assign c_o   = wide[EW-1];
  assign v_o   = ((x_i ^ sum_o) & (y_eff ^ sum_o)) >> (W-1) != '0;

  always_comb begin
    if (invert_i && cin_i)
      p_nb_compare_r5: assert (c_o == (y_i <= x_i))
        else $error("no-borrow carry mismatch");
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (alu_op_e'(op_i))
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         arith_i,
  input  logic         add_c_i,
  input  logic         add_v_i,
  input  logic         shc_i,
  input  logic         set_i,
  input  logic [3:0]   flags_i,
  output logic [3:0]   flags_o
);
  always_comb begin
    flags_o = flags_i;
    if (set_i) begin
      flags_o[FLAG_N] = res_i[W-1];
      flags_o[FLAG_Z] = (res_i == '0);
      flags_o[FLAG_C] = arith_i ? add_c_i : shc_i;
      flags_o[FLAG_V] = arith_i ? add_v_i : flags_i[FLAG_V];
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   op_i,
  input  logic [3:0]   flags_i,
  input  logic         shc_i,
  input  logic         set_flags_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o
);
  alu_ctrl_t    ctrl;
  logic [W-1:0] x, y, sum, log_res;
  logic         add_c, add_v, cin;

  alu_decode u_dec (.op_i(op_i), .ctrl_o(ctrl));

  assign x   = ctrl.swap ? b_i : a_i;
  assign y   = ctrl.swap ? a_i : b_i;
  assign cin = ctrl.use_cin ? flags_i[FLAG_C] : ctrl.invert_y;

  alu_adder #(.W(W)) u_add (
    .x_i(x), .y_i(y), .invert_i(ctrl.invert_y), .cin_i(cin),
    .sum_o(sum), .c_o(add_c), .v_o(add_v)
  );

  alu_logic #(.W(W)) u_log (.op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(log_res));

  assign result_o = ctrl.arith ? sum : log_res;
  assign wr_en_o  = ctrl.write_rd;

  alu_flags #(.W(W)) u_flg (
    .res_i(result_o), .arith_i(ctrl.arith), .add_c_i(add_c), .add_v_i(add_v),
    .shc_i(shc_i), .set_i(set_flags_i), .flags_i(flags_i), .flags_o(flags_o)
  );

  always_comb begin
    if (op_i[3:2] == 2'b10)
      p_test_no_write_r3: assert (!wr_en_o) else $error("compare wrote rd");
    if (!set_flags_i)
      p_flags_hold_r10: assert (flags_o == flags_i) else $error("flags changed");
    if (set_flags_i)
      p_n_sign_r4: assert (flags_o[FLAG_N] == result_o[W-1]) else $error("N wrong");
    if (set_flags_i)
      p_z_zero_r4: assert (flags_o[FLAG_Z] == (result_o == '0)) else $error("Z wrong");
    if (set_flags_i && !ctrl.arith)
      p_logic_cv_r9: assert (flags_o[FLAG_V] == flags_i[FLAG_V] && flags_o[FLAG_C] == shc_i)
        else $error("logical C/V wrong");
  end
endmodule

// File: tb/tb_dp_alu.sv
module tb_dp_alu;
  localparam int W = 32;

  typedef struct {
    logic [3:0]  op;
    logic [31:0] res;
    logic        wr;
    logic [3:0]  fl;
    logic        sf;
  } exp_t;

  logic        clk = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  op = '0, fl_in = '0;
  logic        shc = 1'b0, sf = 1'b0;
  logic [31:0] res;
  logic        wr;
  logic [3:0]  fl_out;
  int total = 0, bad = 0;
  bit finished = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  dp_alu #(.W(W)) dut (
    .a_i(a), .b_i(b), .op_i(op), .flags_i(fl_in), .shc_i(shc),
    .set_flags_i(sf), .result_o(res), .wr_en_o(wr), .flags_o(fl_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s op=%0h act=%h exp=%h", tag, op, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                                 input logic [3:0] f, input logic sh, input logic s);
    exp_t e;
    logic [32:0] t1, t2;
    logic [63:0] sub_ext;
    logic cin, c, v, arith;
    logic [31:0] r, mn, sb;
    cin = f[1]; c = 1'b0; v = 1'b0; arith = 1'b1; r = '0;
    mn = (o == 4'h3 || o == 4'h7) ? y : x;
    sb = (o == 4'h3 || o == 4'h7) ? x : y;
    case (o)
      4'h2, 4'h3, 4'hA: begin
        r = mn - sb; c = (sb <= mn); v = ((mn ^ r) & (~sb ^ r)) >> 31 != 0;
      end
      4'h4, 4'hB: begin
        t1 = {1'b0, x} + {1'b0, y}; r = t1[31:0]; c = t1[32];
        v = ((x ^ r) & (y ^ r)) >> 31 != 0;
      end
      4'h5: begin
        t1 = {1'b0, x} + {1'b0, y};
        t2 = {1'b0, t1[31:0]} + {32'b0, cin};
        r = t2[31:0]; c = t1[32] | t2[32];
        v = ((x ^ r) & (y ^ r)) >> 31 != 0;
      end
      4'h6, 4'h7: begin
        r = mn - sb + {31'b0, cin} - 32'd1;
        sub_ext = {32'b0, sb} - {63'b0, cin} + 64'd1;
        c = (sub_ext <= {32'b0, mn});
        v = ((mn ^ r) & (~sb ^ r)) >> 31 != 0;
      end
      default: begin
        arith = 1'b0; c = sh; v = f[0];
        case (o)
          4'h0, 4'h8: r = x & y;
          4'h1, 4'h9: r = x ^ y;
          4'hC:       r = x | y;
          4'hD:       r = y;
          4'hE:       r = x & ~y;
          default:    r = ~y;
        endcase
      end
    endcase
    e.op = o; e.res = r; e.sf = s;
    e.wr = !(o >= 4'h8 && o <= 4'hB);
    e.fl = s ? {r[31], r == 0, c, v} : f;
    if (!arith) e.fl[0] = f[0];
    return e;
  endfunction

  function automatic string ctag(input logic [3:0] o);
    case (o)
      4'h2, 4'h3, 4'hA: return "R5";
      4'h4, 4'h5, 4'hB: return "R6";
      4'h6, 4'h7:       return "R7";
      default:          return "R9";
    endcase
  endfunction

  function automatic bit is_arith(input logic [3:0] o);
    return (o >= 4'h2 && o <= 4'h7) || o == 4'hA || o == 4'hB;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(res === e.res, is_arith(e.op) ? "R2 result" : "R1 result", res, e.res);
      chk(wr === e.wr, "R3 wr_en", {31'b0, wr}, {31'b0, e.wr});
      if (e.sf) begin
        chk(fl_out[3:2] === e.fl[3:2], "R4 NZ", {28'b0, fl_out}, {28'b0, e.fl});
        chk(fl_out[1] === e.fl[1], {ctag(e.op), " C"}, {28'b0, fl_out}, {28'b0, e.fl});
        chk(fl_out[0] === e.fl[0], is_arith(e.op) ? "R8 V" : "R9 V", {28'b0, fl_out}, {28'b0, e.fl});
      end else begin
        chk(fl_out === e.fl, "R10 hold", {28'b0, fl_out}, {28'b0, e.fl});
      end
    end
  end

  task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [3:0] f, input logic sh, input logic s);
    @(posedge clk);
    #1;
    op = o; a = x; b = y; fl_in = f; shc = sh; sf = s;
    q.push_back(model(o, x, y, f, sh, s));
  endtask

  initial begin
    logic [31:0] va [10];
    logic [31:0] vb [10];
    va = '{32'h0, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h5,
           32'h12345678, 32'h80000000, 32'hFFFFFFFF, 32'h0, 32'h1};
    vb = '{32'h0, 32'h1, 32'h1, 32'h1, 32'h5,
           32'h87654321, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h2};
    // reset-state style check: idle inputs
    #1;
    chk(res === 32'h0 && wr === 1'b1 && fl_out === 4'h0, "R1 idle", res, 32'h0);
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 10; i++)
        for (int c = 0; c < 2; c++)
          drive(o[3:0], va[i], vb[i], {2'b01, c[0], i[0]}, ~c[0], 1'b1);
    for (int n = 0; n < 400; n++)
      drive(4'($urandom), $urandom, $urandom, 4'($urandom), 1'($urandom), (n % 4) != 0);
    // hold with flags clear and set
    for (int o = 0; o < 16; o++) begin
      drive(o[3:0], 32'hFFFFFFFF, 32'h1, 4'hF, 1'b0, 1'b0);
      drive(o[3:0], 32'h0, 32'h0, 4'h0, 1'b1, 1'b0);
    end
    @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule